// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration image into a downstream programmable device over a passive serial link. A single `start_i` pulse begins the sequence. The block holds the target's configuration-reset line low for a timed interval and checks that the target's status line answers low. It then releases the reset line, waits a settle interval, and polls until the status line is released. If the status line is not released within the timeout, the load is abandoned.

Configuration bytes arrive on a valid/ready byte stream that carries a last-byte marker. Each byte is shifted out least significant bit first on a serial data line, and the target samples each bit on the rising edge of a generated serial clock. After the last byte, the block checks the target's configuration-complete input. If that input is high, the block sends a fixed number of trailing clock pulses and reports done. If the load fails at any step, the block drives its outputs to a safe idle state and latches a 2-bit cause code.

All intervals are counted in system clock cycles. The counts are derived from a clock-frequency parameter together with microsecond parameters. The serial clock half-period is derived from a maximum serial-clock frequency parameter.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, the outputs are idle: `tgt_reset_n`=1, `ser_clk`=0, `ser_dat`=0, `in_ready`=0, `busy_o`=0, `done_o`=0, `err_o`=0, `err_code`=00.
- R2: An accepted start drives `tgt_reset_n` low for at least HOLD_US microseconds of clock cycles (2 us by default). It drives it low exactly once per load.
- R3: If `tgt_stat_n` is high at the end of the reset hold, the load fails with `err_code`=01 and no serial clock pulse is sent.
- R4: After release, the block waits SETTLE_US and then polls `tgt_stat_n`. If it is not high within TMO_US, the load fails with `err_code`=10. The failure comes at least SETTLE+TMO cycles after release.
- R5: Bytes are sent LSB first, with 8 rising `ser_clk` edges per byte. `ser_dat` changes only while `ser_clk` is low, and each clock phase lasts HALF system cycles.
- R6: `in_ready` is high only in the data phase, with the shifter empty and the last byte not yet taken. It is never high during the reset, handshake or trailing phases.
- R7: After the last byte, if `tgt_cfg_ok` is low, the load fails with `err_code`=11 and no trailing pulses are sent.
- R8: If `tgt_cfg_ok` is high, exactly TRAIL_PULSES (12) further high-then-low `ser_clk` pulses follow, and then `done_o`=1 with `busy_o`=0.
- R9: On any failure, `err_o`=1, `tgt_reset_n`=1, `ser_clk`=0 and `ser_dat`=0. The code is held until the next accepted start, which clears it to 00.
- R10: A start pulse is ignored while `busy_o` is high.
- R11: `done_o` and `err_o` are never both high, and `busy_o` excludes both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (accepted when not busy) |
| in_data | input | BYTE_W | Configuration byte |
| in_valid | input | 1 | Byte valid |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load completed successfully |
| err_o | output | 1 | Last load failed |
| err_code | output | 2 | Failure cause: 01 no status answer, 10 status timeout, 11 completion missing |
| tgt_reset_n | output | 1 | Active-low configuration reset to the target |
| ser_clk | output | 1 | Serial configuration clock |
| ser_dat | output | 1 | Serial configuration data |
| tgt_stat_n | input | 1 | Target status, low while the target is in reset |
| tgt_cfg_ok | input | 1 | Target configuration-complete flag |

## Verification
The bound checker watches several properties on every cycle. It checks that the reset-hold length is reached before each release, that `ser_dat` holds still through every high clock phase, and that each high phase lasts HALF cycles. It also checks that `in_ready` never rises outside an empty-shifter data phase, and that a failure always leaves the safe output levels with a nonzero code. Other behaviour can only be shown by the bench's scenarios: the bit order across whole images, the exact count of trailing pulses, the length of the timeout, and which cause code each target misbehaviour produces. The bench reaches these by modelling a target that answers, stays silent, never releases, or never completes.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_SETTLE,
    ST_POLL,
    ST_SHIFT,
    ST_TRAIL,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_NO_ACK = 2'b01,
    ERR_TMO    = 2'b10,
    ERR_NO_CFG = 2'b11
  } err_code_t;

  // Cycles covering a time in microseconds, rounded up.
  function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned us);
    return (clk_hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction

  // Half-period in system cycles keeping the serial clock at or below max_hz.
  function automatic longint unsigned half_cycles(input longint unsigned clk_hz,
                                                  input longint unsigned max_hz);
    longint unsigned h;
    h = (clk_hz + 2 * max_hz - 1) / (2 * max_hz);
    return (h == 0) ? 64'd1 : h;
  endfunction

  function automatic longint unsigned max3(input longint unsigned a,
                                           input longint unsigned b,
                                           input longint unsigned c);
    longint unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF   = 2,
  parameter int unsigned TRAIL  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              trail_go,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_dat
);

  localparam int unsigned CW = $clog2(((BYTE_W > TRAIL) ? BYTE_W : TRAIL) + 1);
  localparam int unsigned HW = $clog2(HALF) + 1;

  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     left;
  logic [HW-1:0]     hcnt;
  logic              second;   // in the second phase of the current pulse
  logic              trail_m;  // pulse shape: high-then-low when set
  logic              busy_q, clk_q, dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0; hcnt <= '0; second <= 1'b0; trail_m <= 1'b0;
      busy_q <= 1'b0; clk_q <= 1'b0; dat_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0; clk_q <= 1'b0; dat_q <= 1'b0; second <= 1'b0;
    end else if (load) begin
      sh      <= load_byte;
      left    <= CW'(BYTE_W);
      hcnt    <= HW'(HALF - 1);
      second  <= 1'b0;
      trail_m <= 1'b0;
      busy_q  <= 1'b1;
      clk_q   <= 1'b0;
      dat_q   <= load_byte[0];
    end else if (trail_go) begin
      left    <= CW'(TRAIL);
      hcnt    <= HW'(HALF - 1);
      second  <= 1'b0;
      trail_m <= 1'b1;
      busy_q  <= 1'b1;
      clk_q   <= 1'b1;
    end else if (busy_q) begin
      if (hcnt != '0) begin
        hcnt <= hcnt - 1'b1;
      end else begin
        hcnt <= HW'(HALF - 1);
        if (!second) begin
          second <= 1'b1;
          clk_q  <= ~clk_q;
        end else begin
          second <= 1'b0;
          if (left == CW'(1)) begin
            busy_q <= 1'b0;
            clk_q  <= 1'b0;
          end else begin
            left  <= left - 1'b1;
            clk_q <= trail_m;
            if (!trail_m) begin
              sh    <= {1'b0, sh[BYTE_W-1:1]};
              dat_q <= sh[1];
            end
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign ser_clk = clk_q;
  assign ser_dat = dat_q;

endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int unsigned TW         = 8,
  parameter int unsigned HOLD_CYC   = 250,
  parameter int unsigned SETTLE_CYC = 250,
  parameter int unsigned TMO_CYC    = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          stat_n,
  input  logic          cfg_ok,
  input  logic          sh_busy,
  input  logic          tmr_exp,
  output seq_state_t    state,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_abort,
  output logic          trail_go,
  output logic          in_ready,
  output logic          start_ev,
  output logic          fail_ev,
  output err_code_t     err_code
);

  seq_state_t st, nxt;
  err_code_t  err_q, err_nxt;
  logic       last_q;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_abort = 1'b0;
    trail_go = 1'b0;
    start_ev = 1'b0;
    fail_ev  = 1'b0;
    err_nxt  = ERR_NONE;
    in_ready = (st == ST_SHIFT) && !sh_busy && !last_q;
    sh_load  = in_ready && in_valid;
    case (st)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          nxt      = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = TW'(HOLD_CYC);
          sh_abort = 1'b1;
          start_ev = 1'b1;
        end
      end
      ST_RST: begin
        if (tmr_exp) begin
          if (stat_n) begin
            fail_ev = 1'b1;
            err_nxt = ERR_NO_ACK;
          end else begin
            nxt      = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC);
          end
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          nxt      = ST_POLL;
          tmr_load = 1'b1;
          tmr_val  = TW'(TMO_CYC);
        end
      end
      ST_POLL: begin
        if (stat_n) begin
          nxt = ST_SHIFT;
        end else if (tmr_exp) begin
          fail_ev = 1'b1;
          err_nxt = ERR_TMO;
        end
      end
      ST_SHIFT: begin
        if (last_q && !sh_busy) begin
          if (cfg_ok) begin
            nxt      = ST_TRAIL;
            trail_go = 1'b1;
          end else begin
            fail_ev = 1'b1;
            err_nxt = ERR_NO_CFG;
          end
        end
      end
      ST_TRAIL: begin
        if (!sh_busy) nxt = ST_DONE;
      end
      default: nxt = ST_IDLE;
    endcase
    if (fail_ev) begin
      nxt      = ST_FAIL;
      sh_abort = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err_q  <= ERR_NONE;
      last_q <= 1'b0;
    end else begin
      st <= nxt;
      if (start_ev)               last_q <= 1'b0;
      else if (sh_load && in_last) last_q <= 1'b1;
      if (start_ev)     err_q <= ERR_NONE;
      else if (fail_ev) err_q <= err_nxt;
    end
  end

  assign state    = st;
  assign err_code = err_q;

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned SER_MAX_HZ   = 50_000_000,
  parameter int unsigned HOLD_US      = 2,
  parameter int unsigned SETTLE_US    = 2,
  parameter int unsigned TMO_US       = 100_000,
  parameter int unsigned TRAIL_PULSES = 12,
  parameter int unsigned BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code,
  output logic              tgt_reset_n,
  output logic              ser_clk,
  output logic              ser_dat,
  input  logic              tgt_stat_n,
  input  logic              tgt_cfg_ok
);

  localparam int unsigned HOLD_CYC   = int'(us_to_cycles(CLK_HZ, HOLD_US));
  localparam int unsigned SETTLE_CYC = int'(us_to_cycles(CLK_HZ, SETTLE_US));
  localparam int unsigned TMO_CYC    = int'(us_to_cycles(CLK_HZ, TMO_US));
  localparam int unsigned HALF       = int'(half_cycles(CLK_HZ, SER_MAX_HZ));
  localparam int unsigned TW         = $clog2(max3(HOLD_CYC, SETTLE_CYC, TMO_CYC) + 1);

  seq_state_t    state;
  err_code_t     code;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          sh_load, sh_abort, trail_go, sh_busy;
  logic          start_ev, fail_ev;

  ps_cfg_seq #(
    .TW(TW), .HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .in_valid(in_valid), .in_last(in_last),
    .stat_n(tgt_stat_n), .cfg_ok(tgt_cfg_ok),
    .sh_busy(sh_busy), .tmr_exp(tmr_exp),
    .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_abort(sh_abort), .trail_go(trail_go),
    .in_ready(in_ready), .start_ev(start_ev), .fail_ev(fail_ev),
    .err_code(code)
  );

  ps_cfg_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  ps_cfg_shift #(.BYTE_W(BYTE_W), .HALF(HALF), .TRAIL(TRAIL_PULSES)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(sh_abort), .load(sh_load),
    .load_byte(in_data), .trail_go(trail_go), .busy(sh_busy),
    .ser_clk(ser_clk), .ser_dat(ser_dat)
  );

  assign tgt_reset_n = (state != ST_RST);
  assign busy_o      = (state == ST_RST)   || (state == ST_SETTLE) ||
                       (state == ST_POLL)  || (state == ST_SHIFT)  ||
                       (state == ST_TRAIL);
  assign done_o      = (state == ST_DONE);
  assign err_o       = (state == ST_FAIL);
  assign err_code    = code;

endmodule

// File: rtl/ps_cfg_chk.sv
module ps_cfg_chk #(
  parameter int unsigned HOLD_CYC = 250,
  parameter int unsigned HALF     = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_reset_n,
  input logic       ser_clk,
  input logic       ser_dat,
  input logic       in_ready,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code,
  input logic       sh_busy,
  input logic       start_ev,
  input logic       fail_ev
);

  int unsigned low_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= 0;
      hi_cnt  <= 0;
    end else begin
      if (tgt_reset_n)            low_cnt <= 0;
      else if (low_cnt < HOLD_CYC) low_cnt <= low_cnt + 1;
      if (!ser_clk)               hi_cnt <= 0;
      else if (hi_cnt < HALF)     hi_cnt <= hi_cnt + 1;
    end
  end

  // R2
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_reset_n) |-> low_cnt == HOLD_CYC);

  // R5
  dat_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

  // R5
  hi_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_cnt >= HALF);

  // R6
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!sh_busy && tgt_reset_n && busy_o && !ser_clk));

  // R9
  fail_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev |=> (err_o && tgt_reset_n && !ser_clk && !ser_dat && err_code != 2'b00));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (busy_o && !tgt_reset_n && err_code == 2'b00));

  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o) && !(busy_o && (done_o || err_o)));

  // R9
  err_flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> err_code != 2'b00);

  // R8
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ser_clk);

endmodule

bind ps_cfg_master ps_cfg_chk #(.HOLD_CYC(HOLD_CYC), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_reset_n(tgt_reset_n), .ser_clk(ser_clk),
  .ser_dat(ser_dat), .in_ready(in_ready), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .err_code(err_code), .sh_busy(sh_busy),
  .start_ev(start_ev), .fail_ev(fail_ev)
);

// File: tb/test_ps_cfg_master.sv
`timescale 1ns/1ps
module test_ps_cfg_master;

  localparam int CLK_MHZ  = 125;
  localparam int HOLD_C   = 2 * CLK_MHZ;
  localparam int SETTLE_C = 2 * CLK_MHZ;
  localparam int TMO_US   = 40;
  localparam int TMO_C    = TMO_US * CLK_MHZ;
  localparam int TRAIL    = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, busy_o, done_o, err_o, tgt_reset_n, ser_clk, ser_dat;
  logic [1:0] err_code;
  logic tgt_stat_n, tgt_cfg_ok;

  always #4 clk = ~clk;

  ps_cfg_master #(.CLK_HZ(125_000_000), .TMO_US(TMO_US)) i_ps_cfg_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code(err_code),
    .tgt_reset_n(tgt_reset_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .tgt_stat_n(tgt_stat_n), .tgt_cfg_ok(tgt_cfg_ok)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model: mode 0 answers, 1 never pulls status low, 2 never releases
  int  tmode = 0, rel_delay = 100, tcnt = 0;
  bit  cd_en = 1'b1;
  int  cd_at = 0;
  logic tstat = 1'b1;
  assign tgt_stat_n = tstat;

  // monitor
  logic rises [512];
  int  rise_n = 0, low_run = 0, last_low = 0, falls = 0, rel_cnt = 0;
  int  bad_ready = 0, excl_bad = 0, cur_n = 0;
  logic prev_clk = 1'b0, prev_rst = 1'b1;
  assign tgt_cfg_ok = cd_en && (rise_n >= cd_at);

  always @(negedge clk) begin
    if (tmode == 1) tstat = 1'b1;
    else if (!tgt_reset_n) begin tstat = 1'b0; tcnt = 0; end
    else if (tmode == 0) begin
      if (tcnt >= rel_delay) tstat = 1'b1; else tcnt++;
    end
    if (ser_clk && !prev_clk) begin
      if (rise_n < 512) rises[rise_n] = ser_dat;
      rise_n++;
    end
    prev_clk = ser_clk;
    if (!tgt_reset_n) low_run++;
    else begin if (low_run != 0) last_low = low_run; low_run = 0; end
    if (prev_rst && !tgt_reset_n) falls++;
    prev_rst = tgt_reset_n;
    if (!tgt_reset_n) rel_cnt = 0; else if (busy_o) rel_cnt++;
    if (in_ready && (!tgt_reset_n || rise_n > 8 * cur_n)) bad_ready++;
    if ((done_o && err_o) || (busy_o && (done_o || err_o))) excl_bad++;
  end

  logic [7:0] byte_q [16];

  function automatic int exp_rises(input int n, input bit ok);
    return ok ? 8 * n + TRAIL : 8 * n;
  endfunction

  function automatic int bit_mismatch(input int n);
    int bad = 0;
    for (int i = 0; i < 8 * n; i++)
      if (rises[i] !== byte_q[i / 8][i % 8]) bad++;
    return bad;
  endfunction

  task automatic push(input logic [7:0] b, input bit last);
    in_valid = 1'b1; in_data = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // n bytes from byte_q; poke issues an extra start mid-load
  task automatic run(input int n, input bit send, input bit poke);
    rise_n = 0; falls = 0; cur_n = n; cd_at = 8 * n;
    pulse_start();
    if (send) begin
      for (int k = 0; k < n; k++) begin
        push(byte_q[k], k == n - 1);
        if (poke && k == 0) pulse_start();
      end
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tgt_reset_n == 1'b1, "R1 tgt_reset_n", tgt_reset_n, 1);
    check(ser_clk == 1'b0 && ser_dat == 1'b0, "R1 serial idle", {ser_clk, ser_dat}, 0);
    check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    check({busy_o, done_o, err_o} == 3'b000, "R1 flags", {busy_o, done_o, err_o}, 0);
    check(err_code == 2'b00, "R1 err_code", err_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 R8 random loads
    for (int r = 0; r < 4; r++) begin
      int n = $urandom_range(1, 6);
      tmode = 0; cd_en = 1'b1; rel_delay = $urandom_range(100, 600);
      for (int k = 0; k < n; k++) byte_q[k] = 8'($urandom);
      run(n, 1'b1, 1'b0);
      check(done_o && !err_o && !busy_o, "R8 done after load", {done_o, err_o, busy_o}, 4);
      check(err_code == 2'b00, "R8 code clear", err_code, 0);
      check(rise_n == exp_rises(n, 1'b1), "R8 pulse count", rise_n, exp_rises(n, 1'b1));
      check(bit_mismatch(n) == 0, "R5 bit order", bit_mismatch(n), 0);
      check(last_low >= HOLD_C, "R2 hold length", last_low, HOLD_C);
      check(falls == 1, "R2 single reset", falls, 1);
    end

    // R5 directed patterns
    byte_q[0] = 8'h01; byte_q[1] = 8'h80; byte_q[2] = 8'hFF; byte_q[3] = 8'h00;
    tmode = 0; rel_delay = 400;
    run(4, 1'b1, 1'b0);
    check(bit_mismatch(4) == 0, "R5 directed bits", bit_mismatch(4), 0);
    check(rise_n == exp_rises(4, 1'b1), "R8 directed count", rise_n, exp_rises(4, 1'b1));

    // R3 status never answers
    tmode = 1;
    run(0, 1'b0, 1'b0);
    check(err_o && err_code == 2'b01, "R3 no answer code", err_code, 1);
    check(rise_n == 0, "R3 no clocks", rise_n, 0);
    check(tgt_reset_n && !ser_clk && !ser_dat, "R9 safe outputs",
          {tgt_reset_n, ser_clk, ser_dat}, 4);

    // R9 code cleared by next start
    tmode = 0; rel_delay = 150;
    byte_q[0] = 8'hA5;
    rise_n = 0; cur_n = 1; cd_at = 8;
    pulse_start();
    check(err_code == 2'b00 && busy_o, "R9 code cleared", err_code, 0);
    push(byte_q[0], 1'b1);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    check(done_o, "R9 recovers", done_o, 1);

    // R4 timeout
    tmode = 2;
    run(0, 1'b0, 1'b0);
    check(err_o && err_code == 2'b10, "R4 timeout code", err_code, 2);
    check(rel_cnt >= SETTLE_C + TMO_C, "R4 timeout length", rel_cnt, SETTLE_C + TMO_C);

    // R7 completion missing
    tmode = 0; cd_en = 1'b0; rel_delay = 200;
    for (int k = 0; k < 3; k++) byte_q[k] = 8'($urandom);
    run(3, 1'b1, 1'b0);
    check(err_o && err_code == 2'b11, "R7 no completion code", err_code, 3);
    check(rise_n == exp_rises(3, 1'b0), "R7 no trailing", rise_n, exp_rises(3, 1'b0));
    check(!ser_clk && !ser_dat && tgt_reset_n, "R9 safe after R7", {ser_clk, ser_dat}, 0);

    // R10 start ignored while busy
    cd_en = 1'b1;
    for (int k = 0; k < 3; k++) byte_q[k] = 8'($urandom);
    run(3, 1'b1, 1'b1);
    check(falls == 1, "R10 start ignored", falls, 1);
    check(done_o && bit_mismatch(3) == 0, "R10 load intact", bit_mismatch(3), 0);

    check(bad_ready == 0, "R6 ready outside data", bad_ready, 0);
    check(excl_bad == 0, "R11 flag exclusivity", excl_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule